// File: doc/BRIEF.md
# Sleep-Mode Wake Interrupt Capture Controller

This block watches a set of interrupt lines while the main interrupt controller is powered down and records every wake-up event on them, so that none are lost before the main controller comes back. Each line can be masked, can be set to detect its active-high or active-low level, and can be set to react to a transition (edge mode) or to the level itself (level mode). A captured event sets a sticky status bit. The bit stays set until software acknowledges it or a software reset clears all of them. The OR of all status bits drives a single wake request.

Software programs the block over a simple 32-bit register bus. A write or a read completes in one cycle, and read data is combinational. Lines are grouped in banks of 32. Line n sits in bank n/32, at byte offset (n/32)*4 from each register group base, and uses bit n%32 of that word. Mask, polarity and sensitivity each have a set address and a clear address, so software can change single lines without a read-modify-write sequence. Status bits clear through a dedicated acknowledge address.

Top module: `wake_capture_ctrl`

## Requirements
- R1: After reset every mask bit is 1, every polarity bit is 1 (rising or high), every sensitivity bit is 0 (edge), the enable bit is 0, all status bits are 0 and wake_req is 0.
- R2: A bus access is decoded only when bus_addr[1:0] is 0. The group is bus_addr[7:4] and the bank is bus_addr[3:2]. Writing to group 2 sets the mask bits of that bank where the data bit is 1, and group 3 clears them. Zero data bits leave their lines unchanged. A read of group 1 returns the bank's mask.
- R3: Group 4 sets the polarity bits written as 1, which selects rising (active-high) detection. Group 5 clears them, which selects falling (active-low) detection. A read of group 4 returns the bank's polarity bits.
- R4: Group 6 sets the sensitivity bits written as 1, which selects level mode. Group 7 clears them, which selects edge mode. A read of group 6 returns the bank's sensitivity bits.
- R5: In edge mode, the selected transition of an input sets the line's status bit on the third rising clock edge after the input changes. The other transition sets nothing.
- R6: In level mode, the status bit is set on every cycle in which the synchronised input is at its active level.
- R7: A masked line never sets its status bit.
- R8: While the enable bit (group 0, bank 0, bit 0) is 0, no status bit becomes set.
- R9: A write to group 9 clears the status bits of the bank that are written as 1. If a capture hits the same bit in the same cycle, the capture wins and the bit stays 1.
- R10: Writing 1 to bit 1 of the control word clears every status bit in that cycle, taking priority over captures. The bit reads back as 0, and bit 0 of the same write updates the enable bit.
- R11: wake_req is 1 exactly when at least one status bit is 1.
- R12: A read of group 8 returns the bank's status bits. status_vec shows all status bits, with line n at bit n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_in | input | NUM_BANKS*32 | Asynchronous interrupt lines |
| status_vec | output | NUM_BANKS*32 | Captured status, line n at bit n |
| wake_req | output | 1 | OR of all status bits |

## Verification
Directed patterns separate rising from falling detection by driving both transitions on one line under each polarity, so a swapped polarity or a missing transition filter becomes visible. A level-mode line held active while it is acknowledged separates capture-wins priority from acknowledge-wins priority. The same line released and then acknowledged shows that level capture follows the input. Toggles on a masked line and on a line while the block is disabled separate gating faults from detection faults. A long constrained-random phase then mixes input toggles with random mask, polarity, sensitivity, acknowledge and soft-reset writes, and compares every cycle against a cycle-exact reference model. This exposes latency and bank-offset errors that the directed cases may miss.

// File: rtl/wcc_pkg.sv
// Package: shared constants and register-group codes for the wake capture
// controller. Assumes banks of 32 lines and at most four banks per group.
package wcc_pkg;
    localparam int BANK_W   = 32;
    localparam int BIDX_W   = 2;
    localparam int EN_BIT   = 0;
    localparam int SRST_BIT = 1;

    typedef enum logic [3:0] {
        GRP_CTRL = 4'd0,
        GRP_MASK = 4'd1,
        GRP_MSET = 4'd2,
        GRP_MCLR = 4'd3,
        GRP_PSET = 4'd4,
        GRP_PCLR = 4'd5,
        GRP_SSET = 4'd6,
        GRP_SCLR = 4'd7,
        GRP_STAT = 4'd8,
        GRP_ACK  = 4'd9
    } grp_e;
endpackage

// File: rtl/wcc_sync.sv
// Module: two-flop synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent; no multi-bit coherence is promised.
module wcc_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Two register stages with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/wcc_detect.sv
// Module: per-line event detection. Turns a synchronised input into an
// active-level view using the polarity bit, then forms a capture pulse in
// edge mode (inactive to active) or level mode (active). The pulse is gated
// by mask and by the global enable. Assumes sync_in is already synchronised.
module wcc_detect #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_in,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] sens,
    input  logic         enable,
    output logic [W-1:0] hit
);
    logic [W-1:0] prev_in;
    logic [W-1:0] act_now;
    logic [W-1:0] act_prev;

    // Keep the previous synchronised sample for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_in <= '0;
        else        prev_in <= sync_in;
    end

    // Combine polarity, sensitivity, mask and enable into the capture pulse.
    always_comb begin
        act_now  = ~(sync_in ^ pol);
        act_prev = ~(prev_in ^ pol);
        hit      = {W{enable}} & ~mask & act_now & (sens | ~act_prev);
    end
endmodule

// File: rtl/wcc_regfile.sv
// Module: configuration registers. Per-bank mask, polarity and sensitivity
// with write-one-to-set and write-one-to-clear addresses, the control word,
// and decode of the acknowledge and soft-reset strobes. Assumes the caller
// passes wr_en only for aligned accesses.
module wcc_regfile
    import wcc_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    localparam int NL = NUM_BANKS * BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  grp_e              grp,
    input  logic [BIDX_W-1:0] bank,
    input  logic [BANK_W-1:0] wdata,
    output logic [NL-1:0]     mask,
    output logic [NL-1:0]     pol,
    output logic [NL-1:0]     sens,
    output logic [NL-1:0]     ack_vec,
    output logic              enable,
    output logic              srst
);
    // Control word: the enable bit is stored, the soft-reset bit is a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable <= 1'b0;
        else if (wr_en && grp == GRP_CTRL && bank == '0)
            enable <= wdata[EN_BIT];
    end

    assign srst = wr_en && grp == GRP_CTRL && bank == '0 && wdata[SRST_BIT];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int LO = b * BANK_W;
        logic sel;
        assign sel = wr_en && (bank == BIDX_W'(b));

        // Set and clear writes to mask, polarity and sensitivity of this bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask[LO +: BANK_W] <= '1;
                pol[LO +: BANK_W]  <= '1;
                sens[LO +: BANK_W] <= '0;
            end else if (sel) begin
                case (grp)
                    GRP_MSET: mask[LO +: BANK_W] <= mask[LO +: BANK_W] | wdata;
                    GRP_MCLR: mask[LO +: BANK_W] <= mask[LO +: BANK_W] & ~wdata;
                    GRP_PSET: pol[LO +: BANK_W]  <= pol[LO +: BANK_W] | wdata;
                    GRP_PCLR: pol[LO +: BANK_W]  <= pol[LO +: BANK_W] & ~wdata;
                    GRP_SSET: sens[LO +: BANK_W] <= sens[LO +: BANK_W] | wdata;
                    GRP_SCLR: sens[LO +: BANK_W] <= sens[LO +: BANK_W] & ~wdata;
                    default: ;
                endcase
            end
        end

        // Acknowledge strobe for this bank, live only during the write cycle.
        assign ack_vec[LO +: BANK_W] = (sel && grp == GRP_ACK) ? wdata : '0;
    end
endmodule

// File: rtl/wcc_capture.sv
// Module: sticky status latches. A capture pulse sets a bit, an acknowledge
// clears it unless a capture hits it in the same cycle, and the soft reset
// clears everything with top priority.
module wcc_capture #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hit,
    input  logic [W-1:0] ack_vec,
    input  logic         srst,
    output logic [W-1:0] status
);
    logic past_ok;

    // Status update: soft reset first, then acknowledge, then capture.
    always_ff @(posedge clk) begin
        if (!rst_n)    status <= '0;
        else if (srst) status <= '0;
        else           status <= (status & ~ack_vec) | hit;
    end

    // Marks cycles that have a valid previous cycle for the checks.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((status & $past(ack_vec & ~hit)) == '0)); // R9
    AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(srst)) |-> ((status & $past(hit)) == $past(hit))); // R9
    AST_SRST_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(srst)) |-> (status == '0)); // R10
endmodule

// File: rtl/wake_capture_ctrl.sv
// Module: top of the sleep-mode wake interrupt capture controller. Decodes
// the single-cycle register bus, ties synchroniser, detector, register file
// and status latches together, and drives the read mux and wake request.
// Assumes NUM_BANKS is between 1 and 4 and that only aligned accesses are used.
module wake_capture_ctrl
    import wcc_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    localparam int NL = NUM_BANKS * BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [BANK_W-1:0] bus_wdata,
    output logic [BANK_W-1:0] bus_rdata,
    input  logic [NL-1:0]     irq_in,
    output logic [NL-1:0]     status_vec,
    output logic              wake_req
);
    logic              aligned;
    grp_e              grp;
    logic [BIDX_W-1:0] bank;
    logic              bank_ok;
    logic              wr_en;
    logic [NL-1:0]     sync_in, mask, pol, sens, ack_vec, hit;
    logic              enable, srst;
    logic              past_ok;

    // Address decode into group and bank.
    always_comb begin
        aligned = (bus_addr[1:0] == 2'b00);
        grp     = grp_e'(bus_addr[7:4]);
        bank    = bus_addr[3:2];
        bank_ok = (int'(bank) < NUM_BANKS);
        wr_en   = bus_sel && bus_wr && aligned;
    end

    wcc_sync #(.W(NL)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(irq_in), .q(sync_in)
    );

    wcc_regfile #(.NUM_BANKS(NUM_BANKS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .grp(grp), .bank(bank),
        .wdata(bus_wdata), .mask(mask), .pol(pol), .sens(sens),
        .ack_vec(ack_vec), .enable(enable), .srst(srst)
    );

    wcc_detect #(.W(NL)) u_det (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .mask(mask), .pol(pol),
        .sens(sens), .enable(enable), .hit(hit)
    );

    wcc_capture #(.W(NL)) u_cap (
        .clk(clk), .rst_n(rst_n), .hit(hit), .ack_vec(ack_vec), .srst(srst),
        .status(status_vec)
    );

    // Read mux: combinational data for aligned reads of readable groups.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr && aligned) begin
            if (grp == GRP_CTRL) begin
                if (bank == '0) bus_rdata[EN_BIT] = enable;
            end else if (bank_ok) begin
                case (grp)
                    GRP_MASK: bus_rdata = mask[int'(bank)*BANK_W +: BANK_W];
                    GRP_PSET: bus_rdata = pol[int'(bank)*BANK_W +: BANK_W];
                    GRP_SSET: bus_rdata = sens[int'(bank)*BANK_W +: BANK_W];
                    GRP_STAT: bus_rdata = status_vec[int'(bank)*BANK_W +: BANK_W];
                    default:  bus_rdata = '0;
                endcase
            end
        end
    end

    // Wake request combines every captured line.
    assign wake_req = |status_vec;

    // Marks cycles that have a valid previous cycle for the checks.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_MASKED_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((status_vec & ~$past(status_vec) & $past(mask)) == '0)); // R7
    AST_DISABLED_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(enable)) |-> ((status_vec & ~$past(status_vec)) == '0)); // R8
    AST_RESET_ALL_MASKED: assert property (@(posedge clk)
        $past(!rst_n) |-> (mask == '1 && status_vec == '0 && !enable)); // R1
endmodule

// File: tb/sim_wake_capture_ctrl.sv
module sim_wake_capture_ctrl;
    localparam int NB = 2;
    localparam int NL = NB * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] irq_in = '0;
    logic [NL-1:0] status_vec;
    logic          wake_req;

    int vectors = 0;
    int errors = 0;

    always #2 clk = ~clk;

    wake_capture_ctrl #(.NUM_BANKS(NB)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .status_vec(status_vec), .wake_req(wake_req)
    );

    // Reference model state, written from the requirements.
    logic [NL-1:0] m_mask, m_pol, m_sens, m_stat, m_s1, m_s2, m_prev;
    logic          m_en;

    always @(posedge clk) begin
        logic [NL-1:0] act, pact, hit, clr;
        logic          srst;
        int            g, b;
        if (!rst_n) begin
            m_mask = '1; m_pol = '1; m_sens = '0; m_stat = '0;
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_en = 1'b0;
        end else begin
            act  = ~(m_s2 ^ m_pol);
            pact = ~(m_prev ^ m_pol);
            hit  = {NL{m_en}} & ~m_mask & act & (m_sens | ~pact);
            clr  = '0;
            srst = 1'b0;
            if (bus_sel && bus_wr && bus_addr[1:0] == 2'b00) begin
                g = int'(bus_addr[7:4]);
                b = int'(bus_addr[3:2]);
                if (g == 0) begin
                    if (b == 0) begin
                        m_en = bus_wdata[0];
                        srst = bus_wdata[1];
                    end
                end else if (b < NB) begin
                    case (g)
                        2: m_mask[b*32 +: 32] = m_mask[b*32 +: 32] | bus_wdata;
                        3: m_mask[b*32 +: 32] = m_mask[b*32 +: 32] & ~bus_wdata;
                        4: m_pol[b*32 +: 32]  = m_pol[b*32 +: 32] | bus_wdata;
                        5: m_pol[b*32 +: 32]  = m_pol[b*32 +: 32] & ~bus_wdata;
                        6: m_sens[b*32 +: 32] = m_sens[b*32 +: 32] | bus_wdata;
                        7: m_sens[b*32 +: 32] = m_sens[b*32 +: 32] & ~bus_wdata;
                        9: clr[b*32 +: 32]    = bus_wdata;
                        default: ;
                    endcase
                end
            end
            m_stat = srst ? '0 : ((m_stat & ~clr) | hit);
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = irq_in;
        end
    end

    function automatic logic [31:0] model_read(input logic [7:0] a);
        int g = int'(a[7:4]);
        int b = int'(a[3:2]);
        if (a[1:0] != 2'b00) return '0;
        if (g == 0) return (b == 0) ? {31'd0, m_en} : '0;
        if (b >= NB) return '0;
        case (g)
            1: return m_mask[b*32 +: 32];
            4: return m_pol[b*32 +: 32];
            6: return m_sens[b*32 +: 32];
            8: return m_stat[b*32 +: 32];
            default: return '0;
        endcase
    endfunction

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: advance, then compare the outputs against the model.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        check(status_vec, m_stat, "R12 status_vec vs model");
        check({63'd0, wake_req}, {63'd0, |m_stat}, "R11 wake_req");
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        check({32'd0, bus_rdata}, {32'd0, model_read(a)}, tag);
        tick();
        bus_sel = 1'b0;
    endtask

    task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        check({32'd0, bus_rdata}, {32'd0, e}, tag);
        tick();
        bus_sel = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        ticks(3);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        rd_exp(8'h10, 32'hFFFF_FFFF, "R1 mask bank0");
        rd_exp(8'h14, 32'hFFFF_FFFF, "R1 mask bank1");
        rd_exp(8'h40, 32'hFFFF_FFFF, "R1 polarity bank0");
        rd_exp(8'h60, 32'h0, "R1 sensitivity bank0");
        rd_exp(8'h00, 32'h0, "R1 control");
        check(status_vec, 64'd0, "R1 status");
        // R2 clear mask of line 40 and line 5
        wr(8'h34, 32'h0000_0100);
        rd_exp(8'h14, 32'hFFFF_FEFF, "R2 unmask line 40");
        wr(8'h30, 32'h0000_0020);
        rd_exp(8'h10, 32'hFFFF_FFDF, "R2 unmask line 5");
        wr(8'h20, 32'h0000_0001);
        rd_exp(8'h10, 32'hFFFF_FFDF, "R2 set of masked bit keeps others");
        wr(8'h00, 32'h1);
        // R5 rising edge on line 5
        irq_in[5] = 1'b1;
        ticks(2);
        check(status_vec[5], 1'b0, "R5 not before third edge");
        tick();
        check(status_vec[5], 1'b1, "R5 rising capture");
        check(wake_req, 1'b1, "R11 wake asserted");
        rd_exp(8'h80, 32'h0000_0020, "R12 status read");
        wr(8'h90, 32'h0000_0020);
        check(status_vec[5], 1'b0, "R9 ack clears");
        ticks(3);
        check(status_vec[5], 1'b0, "R5 no re-capture while held");
        irq_in[5] = 1'b0;
        ticks(4);
        check(status_vec[5], 1'b0, "R5 falling ignored in rising mode");
        // R3 switch line 5 to falling
        wr(8'h50, 32'h0000_0020);
        rd_exp(8'h40, 32'hFFFF_FFDF, "R3 polarity readback");
        irq_in[5] = 1'b1;
        ticks(4);
        check(status_vec[5], 1'b0, "R3 rising ignored in falling mode");
        irq_in[5] = 1'b0;
        ticks(3);
        check(status_vec[5], 1'b1, "R3 falling capture");
        wr(8'h90, 32'h0000_0020);
        // R4 and R6 level mode on line 40
        wr(8'h64, 32'h0000_0100);
        rd_exp(8'h64, 32'h0000_0100, "R4 sensitivity set readback");
        irq_in[40] = 1'b1;
        ticks(3);
        check(status_vec[40], 1'b1, "R6 level capture");
        wr(8'h94, 32'h0000_0100);
        check(status_vec[40], 1'b1, "R9 capture wins over ack");
        irq_in[40] = 1'b0;
        ticks(3);
        wr(8'h94, 32'h0000_0100);
        check(status_vec[40], 1'b0, "R6 released level acked");
        wr(8'h74, 32'h0000_0100);
        rd_exp(8'h64, 32'h0, "R4 sensitivity clear readback");
        // R7 masked line
        irq_in[7] = 1'b1;
        ticks(4);
        irq_in[7] = 1'b0;
        ticks(4);
        check(status_vec, 64'd0, "R7 masked line silent");
        // R8 disabled
        wr(8'h00, 32'h0);
        irq_in[5] = 1'b1;
        ticks(3);
        irq_in[5] = 1'b0;
        ticks(4);
        check(status_vec, 64'd0, "R8 disabled no capture");
        wr(8'h00, 32'h1);
        ticks(3);
        check(status_vec, 64'd0, "R8 lost event stays lost");
        // R10 soft reset
        irq_in[5] = 1'b1;
        tick();
        irq_in[5] = 1'b0;
        ticks(4);
        check(status_vec[5], 1'b1, "R10 precondition capture");
        wr(8'h00, 32'h3);
        check(status_vec, 64'd0, "R10 soft reset clears");
        rd_exp(8'h00, 32'h1, "R10 srst reads zero, enable kept");
        // Random phase against the model
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h34, 32'hFFFF_FFFF);
        for (int n = 0; n < 4000; n++) begin
            int op = int'($urandom % 16);
            for (int k = 0; k < 3; k++)
                irq_in[$urandom % NL] = 1'($urandom);
            if (op < 3) begin
                logic [7:0] a;
                int grp = int'($urandom % 10);
                logic [31:0] d = $urandom & $urandom;
                a = {4'(grp), 2'($urandom % 2), 2'b00};
                if (grp == 0) d = {30'd0, ($urandom % 8) == 0, ($urandom % 6) != 0};
                if (grp == 2) d = d & $urandom;
                wr(a, d);
            end else if (op < 5) begin
                rd({4'($urandom % 10), 2'($urandom % 4), 2'($urandom % 4 == 0)},
                   "R12 random read");
            end else begin
                tick();
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule